// File: doc/BRIEF.md
# Two-Wire EEPROM Target Sequencer

This block is the byte-level control core of a serial EEPROM target on a two-wire bus. A separate bit engine turns the pins into single-cycle events: start, stop, a received byte, the master's acknowledge bit after a sent byte, and a request for the next byte to send. The sequencer decides which received bytes get an acknowledge. It decodes the select byte to reach either the main array or a 16-byte read-only identification area, and loads the word pointer. It issues read fetches and gathers write data in a page buffer.

When a write ends with a stop, the block commits the buffered bytes to the array port. It then stays busy for a fixed number of clock cycles and ignores the bus during that time. A write-protect input blocks the commit, but the bytes are still acknowledged.

The states and their transitions are as follows:
- `ST_IDLE` waits for a start.
- `ST_SEL` expects the select byte. A matching select moves to `ST_READ` if bit 0 is 1, or to `ST_WADDR` if bit 0 is 0. Any other select byte returns to `ST_IDLE`.
- `ST_WADDR` loads the pointer and moves to `ST_WDATA`.
- `ST_WDATA` stores data until a stop. The stop moves to `ST_WCYCLE` when there is something to commit, or to `ST_IDLE` otherwise.
- `ST_READ` serves fetches. A master NACK returns it to `ST_IDLE`.
- `ST_WCYCLE` returns to `ST_IDLE` after `WR_CYCLES` cycles.
- A start in any state except `ST_WCYCLE` moves to `ST_SEL`.
- A stop in any state except `ST_WCYCLE` and `ST_WDATA` moves to `ST_IDLE`.

Top module: `eets_seq`

## Requirements
- R1: A select byte with bits 7:4 = 1010 addresses the main array and 1011 addresses the ID area. Any other upper nibble is not acknowledged, and later bytes are not acknowledged either until the next start.
- R2: With SMALL_ARRAY=0, select bit 3 must equal hw_addr[1], and bits 2:1 become address bits 9:8. With SMALL_ARRAY=1, bits 3:2 must equal hw_addr, and bit 1 becomes address bit 8. A pin mismatch is not acknowledged.
- R3: An acknowledged byte raises ack_o for exactly one cycle, in the cycle after ev_byte. Select bit 0 = 1 starts a read and 0 starts a write. A write's word address and data bytes are all acknowledged.
- R4: A stop in `ST_WDATA` with buffered main-array data starts the write cycle. Each buffered entry is written in order of slot index 0..15, with wr_addr_o = {page, slot}. Writes start one cycle after busy_o rises.
- R5: busy_o stays high for exactly WR_CYCLES cycles. While it is high, no byte is acknowledged. After it falls, a select byte is acknowledged again.
- R6: The data bytes advance only the low 4 address bits, so a 17th byte overwrites the first. Only slots that were written are committed.
- R7: Each ev_rdreq in `ST_READ` yields rd_en_o with the current address in the next cycle and then advances the pointer. The main-array pointer wraps from the top address to 0. A master NACK ends the read.
- R8: While wp_i is high at the stop, the bytes are still acknowledged, but no write cycle starts and wr_en_o stays low.
- R9: For the ID area, the word address sets a 4-bit index. Reads raise rd_id_o and wrap from index 15 to 0. Data written to the ID area is acknowledged, but it is never committed.
- R10: A start in any state except the write cycle returns the block to select decoding and drops a pending write. A byte that arrives in idle is not acknowledged.
- R11: A read issued without a word address continues from the pointer that the last operation left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ev_start | input | 1 | Start condition seen |
| ev_stop | input | 1 | Stop condition seen |
| ev_byte | input | 1 | A received byte is valid on rx_byte |
| rx_byte | input | 8 | Received byte |
| ev_rdreq | input | 1 | Bit engine needs the next byte to send |
| ev_mack | input | 1 | Master acknowledge bit sampled |
| mack_nack | input | 1 | 1 when that bit was a NACK |
| hw_addr | input | 2 | Strap pins (bit 1 = upper) |
| wp_i | input | 1 | Write protect |
| ack_o | output | 1 | Drive ACK for the last byte |
| rd_en_o | output | 1 | Fetch strobe |
| rd_id_o | output | 1 | Fetch targets the ID area |
| rd_addr_o | output | 10 | Fetch address (9 bits when SMALL_ARRAY=1) |
| wr_en_o | output | 1 | Array write strobe |
| wr_addr_o | output | 10 | Array write address |
| wr_data_o | output | 8 | Array write data |
| busy_o | output | 1 | Internal write cycle running |

## Verification
Every event input is sampled at one clock edge, and the output it causes is registered at that same edge. As a result, ack_o, rd_en_o and rd_addr_o are due in the cycle after the event, and busy_o rises in the cycle after the stop. The first array write follows one cycle later, and the remaining writes follow on consecutive cycles. The bench drives each event on a falling edge for one cycle and checks the result on the next falling edge. It measures the length of the busy period by counting falling edges between the rise and the fall of busy_o.

// File: rtl/eets_pkg.sv
package eets_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_WADDR,
        ST_WDATA,
        ST_READ,
        ST_WCYCLE
    } seq_state_t;
endpackage

// File: rtl/eets_sel_decode.sv
module eets_sel_decode #(
    parameter bit SMALL_ARRAY = 1'b0
) (
    input  logic [7:0] sel_byte,
    input  logic [1:0] hw_addr,
    output logic       hit,
    output logic       to_id,
    output logic       is_read,
    output logic [1:0] page
);
    logic pins_ok;
    logic main_nib;

    generate
        if (SMALL_ARRAY) begin : g_small
            assign pins_ok = (sel_byte[3:2] == hw_addr);
            assign page    = {1'b0, sel_byte[1]};
        end else begin : g_large
            assign pins_ok = (sel_byte[3] == hw_addr[1]);
            assign page    = sel_byte[2:1];
        end
    endgenerate

    assign main_nib = (sel_byte[7:4] == 4'hA);
    assign to_id    = (sel_byte[7:4] == 4'hB);
    assign hit      = (main_nib || to_id) && pins_ok;
    assign is_read  = sel_byte[0];
endmodule

// File: rtl/eets_page_buf.sv
module eets_page_buf #(
    parameter int DEPTH = 16,
    localparam int IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx,
    output logic          rvld,
    output logic [7:0]    rdata,
    output logic          any_vld
);
    logic [7:0]       slot_q [DEPTH];
    logic [DEPTH-1:0] vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (clr) begin
            vld_q <= '0;
        end else if (we) begin
            vld_q[widx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !clr) begin
            slot_q[widx] <= wdata;
        end
    end

    assign rvld    = vld_q[ridx];
    assign rdata   = slot_q[ridx];
    assign any_vld = |vld_q;
endmodule

// File: rtl/eets_wr_timer.sv
module eets_wr_timer #(
    parameter int CYCLES = 64,
    parameter int SLOTS  = 16,
    localparam int CW = $clog2(CYCLES + 1),
    localparam int SW = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run_i,
    output logic [SW-1:0] slot_o,
    output logic          commit_o,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign slot_o   = cnt_q[SW-1:0];
    assign commit_o = run_i && (cnt_q < CW'(SLOTS));
    assign last_o   = run_i && (cnt_q == CW'(CYCLES - 1));
endmodule

// File: rtl/eets_seq.sv
module eets_seq
    import eets_pkg::*;
#(
    parameter bit SMALL_ARRAY = 1'b0,
    parameter int WR_CYCLES   = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              ev_start,
    input  logic                              ev_stop,
    input  logic                              ev_byte,
    input  logic [7:0]                        rx_byte,
    input  logic                              ev_rdreq,
    input  logic                              ev_mack,
    input  logic                              mack_nack,
    input  logic [1:0]                        hw_addr,
    input  logic                              wp_i,
    output logic                              ack_o,
    output logic                              rd_en_o,
    output logic                              rd_id_o,
    output logic [(SMALL_ARRAY ? 9 : 10)-1:0] rd_addr_o,
    output logic                              wr_en_o,
    output logic [(SMALL_ARRAY ? 9 : 10)-1:0] wr_addr_o,
    output logic [7:0]                        wr_data_o,
    output logic                              busy_o
);
    localparam int ADDR_W = SMALL_ARRAY ? 9 : 10;
    localparam int PG_W   = ADDR_W - 8;
    localparam int SLOTS  = 16;
    localparam int SW     = $clog2(SLOTS);

    seq_state_t        state_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [PG_W-1:0]   page_q;
    logic              tgt_id_q;

    logic              dec_hit, dec_id, dec_rd;
    logic [1:0]        dec_page;
    logic              buf_clr, buf_we, buf_rvld, buf_any;
    logic [7:0]        buf_rdata;
    logic [SW-1:0]     tm_slot;
    logic              tm_commit, tm_last, run_wc;

    eets_sel_decode #(.SMALL_ARRAY(SMALL_ARRAY)) u_dec (
        .sel_byte(rx_byte), .hw_addr(hw_addr), .hit(dec_hit),
        .to_id(dec_id), .is_read(dec_rd), .page(dec_page)
    );

    assign buf_clr = (state_q == ST_WADDR) && ev_byte;
    assign buf_we  = (state_q == ST_WDATA) && ev_byte && !tgt_id_q;
    assign run_wc  = (state_q == ST_WCYCLE);

    eets_page_buf #(.DEPTH(SLOTS)) u_buf (
        .clk(clk), .rst_n(rst_n), .clr(buf_clr), .we(buf_we),
        .widx(ptr_q[SW-1:0]), .wdata(rx_byte), .ridx(tm_slot),
        .rvld(buf_rvld), .rdata(buf_rdata), .any_vld(buf_any)
    );

    eets_wr_timer #(.CYCLES(WR_CYCLES), .SLOTS(SLOTS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .run_i(run_wc),
        .slot_o(tm_slot), .commit_o(tm_commit), .last_o(tm_last)
    );

    // State register and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            page_q   <= '0;
            tgt_id_q <= 1'b0;
        end else if (state_q == ST_WCYCLE) begin
            if (tm_last) state_q <= ST_IDLE;
        end else if (ev_start) begin
            state_q <= ST_SEL;
        end else if (ev_stop) begin
            state_q <= (state_q == ST_WDATA && buf_any && !wp_i && !tgt_id_q)
                       ? ST_WCYCLE : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: ;
                ST_SEL: if (ev_byte) begin
                    if (!dec_hit) begin
                        state_q <= ST_IDLE;
                    end else begin
                        tgt_id_q <= dec_id;
                        page_q   <= dec_page[PG_W-1:0];
                        state_q  <= dec_rd ? ST_READ : ST_WADDR;
                    end
                end
                ST_WADDR: if (ev_byte) begin
                    ptr_q   <= tgt_id_q ? {{(ADDR_W-SW){1'b0}}, rx_byte[SW-1:0]}
                                        : {page_q, rx_byte};
                    state_q <= ST_WDATA;
                end
                ST_WDATA: if (ev_byte && !tgt_id_q) begin
                    ptr_q <= {ptr_q[ADDR_W-1:SW], ptr_q[SW-1:0] + 1'b1};
                end
                ST_READ: begin
                    if (ev_rdreq) begin
                        ptr_q <= tgt_id_q ? {ptr_q[ADDR_W-1:SW], ptr_q[SW-1:0] + 1'b1}
                                          : ptr_q + 1'b1;
                    end
                    if (ev_mack && mack_nack) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_o     <= 1'b0;
            rd_en_o   <= 1'b0;
            rd_id_o   <= 1'b0;
            rd_addr_o <= '0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
        end else begin
            ack_o   <= ev_byte && !ev_start && !ev_stop &&
                       ((state_q == ST_SEL && dec_hit) ||
                        state_q == ST_WADDR || state_q == ST_WDATA);
            rd_en_o <= (state_q == ST_READ) && ev_rdreq && !ev_start && !ev_stop;
            if ((state_q == ST_READ) && ev_rdreq) begin
                rd_id_o   <= tgt_id_q;
                rd_addr_o <= tgt_id_q ? {{(ADDR_W-SW){1'b0}}, ptr_q[SW-1:0]} : ptr_q;
            end
            wr_en_o   <= tm_commit && buf_rvld;
            wr_addr_o <= {ptr_q[ADDR_W-1:SW], tm_slot};
            wr_data_o <= buf_rdata;
        end
    end

    assign busy_o = run_wc;

    assert_ack_follows_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(ev_byte));
    assert_silent_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> !ack_o);
    assert_write_inside_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> busy_o);
    assert_protect_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && wp_i && !busy_o) |=> !busy_o);
    assert_no_fetch_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !busy_o);
endmodule

// File: tb/tb_eets_seq.sv
module tb_eets_seq;
    localparam int WR_CYCLES = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 0, ev_stop = 0, ev_byte = 0, ev_rdreq = 0, ev_mack = 0, mack_nack = 0;
    logic [7:0] rx_byte = '0;
    logic [1:0] hw_addr = 2'b10;
    logic       wp_i = 1'b0;
    logic       ack_o, rd_en_o, rd_id_o, wr_en_o, busy_o;
    logic [9:0] rd_addr_o, wr_addr_o;
    logic [7:0] wr_data_o;

    int checks = 0, errors = 0, cyc = 0, wn = 0;
    logic [9:0] wlog_a [32];
    logic [7:0] wlog_d [32];

    always #10 clk = ~clk;

    eets_seq #(.SMALL_ARRAY(1'b0), .WR_CYCLES(WR_CYCLES)) dut (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .ev_byte(ev_byte), .rx_byte(rx_byte), .ev_rdreq(ev_rdreq), .ev_mack(ev_mack),
        .mack_nack(mack_nack), .hw_addr(hw_addr), .wp_i(wp_i), .ack_o(ack_o),
        .rd_en_o(rd_en_o), .rd_id_o(rd_id_o), .rd_addr_o(rd_addr_o), .wr_en_o(wr_en_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .busy_o(busy_o)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (wr_en_o && wn < 32) begin
            wlog_a[wn] = wr_addr_o;
            wlog_d[wn] = wr_data_o;
            wn = wn + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_start();
        @(negedge clk); ev_start = 1;
        @(negedge clk); ev_start = 0;
    endtask

    task automatic do_stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
    endtask

    task automatic send(input logic [7:0] b, input bit exp_ack, input string tag);
        @(negedge clk); ev_byte = 1; rx_byte = b;
        @(negedge clk); ev_byte = 0;
        chk(ack_o == exp_ack, tag, ack_o, exp_ack);
    endtask

    task automatic fetch(input logic [9:0] exp_a, input bit exp_id, input string tag);
        @(negedge clk); ev_rdreq = 1;
        @(negedge clk); ev_rdreq = 0;
        chk(rd_en_o && rd_addr_o == exp_a && rd_id_o == exp_id, tag,
            {rd_en_o, rd_id_o, rd_addr_o}, {1'b1, exp_id, exp_a});
    endtask

    task automatic mack(input bit nack);
        @(negedge clk); ev_mack = 1; mack_nack = nack;
        @(negedge clk); ev_mack = 0; mack_nack = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 200 && busy_o; i++) @(negedge clk);
    endtask

    // R2 R4: single byte write to page 01
    task automatic t_byte_write();
        wn = 0;
        do_start(); send(8'hAA, 1, "R2 select page01"); send(8'h35, 1, "R3 waddr");
        send(8'h5C, 1, "R3 data"); do_stop();
        chk(busy_o == 1, "R4 busy after stop", busy_o, 1);
        wait_idle();
        chk(wn == 1 && wlog_a[0] == 10'h135 && wlog_d[0] == 8'h5C, "R4 commit",
            {wn[7:0], wlog_a[0], wlog_d[0]}, {8'd1, 10'h135, 8'h5C});
    endtask

    // R5: busy length, silence, polling
    task automatic t_busy();
        int c0;
        do_start(); send(8'hA8, 1, "R5 sel"); send(8'h10, 1, "R5 waddr");
        send(8'h01, 1, "R5 data");
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0; c0 = cyc;
        do_start(); send(8'hA8, 0, "R5 no ack while busy");
        wait_idle();
        chk(cyc - c0 == WR_CYCLES, "R5 busy length", cyc - c0, WR_CYCLES);
        do_start(); send(8'hA9, 1, "R5 poll acked"); mack(1); do_stop();
    endtask

    // R6: page roll-over and partial page
    task automatic t_page();
        int bad = 0;
        wn = 0;
        do_start(); send(8'hA8, 1, "R6 sel"); send(8'h0E, 1, "R6 waddr");
        for (int k = 0; k < 18; k++) send(8'hD0 + 8'(k), 1, "R6 data ack");
        do_stop(); wait_idle();
        for (int s = 0; s < 16; s++) begin
            logic [7:0] e;
            e = (s == 14) ? 8'hE0 : (s == 15) ? 8'hE1 : 8'hD2 + 8'(s);
            if (wlog_a[s] != 10'(s) || wlog_d[s] != e) bad++;
        end
        chk(wn == 16 && bad == 0, "R6 wrap overwrite", wn * 100 + bad, 1600);
        wn = 0;
        do_start(); send(8'hAC, 1, "R6 sel page10"); send(8'h43, 1, "R6 waddr");
        send(8'h61, 1, "R6 d0"); send(8'h62, 1, "R6 d1"); send(8'h63, 1, "R6 d2");
        do_stop(); wait_idle();
        chk(wn == 3 && wlog_a[0] == 10'h243 && wlog_a[2] == 10'h245 && wlog_d[2] == 8'h63,
            "R6 partial page", wn, 3);
    endtask

    // R11 R7 R10: current address read, NACK end, idle byte ignored
    task automatic t_cur_read();
        do_start(); send(8'hA9, 1, "R11 sel read");
        fetch(10'h246, 0, "R11 current address"); mack(0);
        fetch(10'h247, 0, "R7 next address"); mack(1);
        send(8'h00, 0, "R10 byte in idle ignored");
        do_stop();
    endtask

    // R7: random then sequential read across top of array
    task automatic t_seq_wrap();
        do_start(); send(8'hAE, 1, "R7 dummy write sel"); send(8'hFF, 1, "R7 waddr");
        do_start(); send(8'hAF, 1, "R7 read sel");
        fetch(10'h3FF, 0, "R7 top address"); mack(0);
        fetch(10'h000, 0, "R7 wrap to zero"); mack(1); do_stop();
        chk(busy_o == 0, "R7 read stop no cycle", busy_o, 0);
    endtask

    // R9: ID area
    task automatic t_id();
        wn = 0;
        do_start(); send(8'hB8, 1, "R9 id sel write"); send(8'h80, 1, "R9 waddr");
        send(8'h55, 1, "R9 id data acked"); do_stop();
        chk(busy_o == 0 && wn == 0, "R9 id never written", {busy_o, wn[7:0]}, 0);
        do_start(); send(8'hB8, 1, "R9 id sel"); send(8'h8E, 1, "R9 waddr 8E");
        do_start(); send(8'hB9, 1, "R9 id read sel");
        fetch(10'h00E, 1, "R9 idx E"); mack(0);
        fetch(10'h00F, 1, "R9 idx F"); mack(0);
        fetch(10'h000, 1, "R9 wrap idx 0"); mack(1); do_stop();
    endtask

    // R8: write protect
    task automatic t_wp();
        wn = 0; wp_i = 1;
        do_start(); send(8'hA8, 1, "R8 sel"); send(8'h20, 1, "R8 waddr acked");
        send(8'h99, 1, "R8 data acked"); do_stop();
        chk(busy_o == 0, "R8 no write cycle", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(wn == 0, "R8 no array write", wn, 0);
        wp_i = 0;
    endtask

    // R1 R2: rejected selects
    task automatic t_bad_sel();
        do_start(); send(8'hC8, 0, "R1 bad nibble"); send(8'h00, 0, "R1 later byte ignored");
        do_start(); send(8'hA0, 0, "R2 pin mismatch"); do_stop();
    endtask

    // R10: start aborts a pending write
    task automatic t_restart();
        wn = 0;
        do_start(); send(8'hA8, 1, "R10 sel"); send(8'h20, 1, "R10 waddr");
        send(8'h11, 1, "R10 data");
        do_start(); do_stop();
        chk(busy_o == 0, "R10 start drops write", busy_o, 0);
        repeat (20) @(negedge clk);
        chk(wn == 0, "R10 nothing committed", wn, 0);
        do_start(); send(8'hA9, 1, "R10 select after restart"); mack(1); do_stop();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ack_o == 0 && busy_o == 0 && wr_en_o == 0 && rd_en_o == 0, "reset outputs",
            {ack_o, busy_o, wr_en_o, rd_en_o}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_byte_write();
        t_busy();
        t_page();
        t_cur_read();
        t_seq_wrap();
        t_id();
        t_wp();
        t_bad_sel();
        t_restart();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule